// File: doc/BRIEF.md
# Dual-Mode Synchronous Queue with Programmable Thresholds

The block is a single-clock first-in/first-out store of 9-bit words, 1024 deep by default. It has two read behaviours, chosen at hard reset. In standard mode a word leaves the queue only when the reader asks for it with the read enable. In fall-through mode the oldest stored word is moved onto the output bus without being asked for. The read enable then only consumes the word on the bus, and the next word takes its place.

There are two status outputs whose meaning follows the read mode. In standard mode they report full and empty. In fall-through mode they report input-ready and output-ready. Three level indicators (half-full, almost-full and almost-empty) compare the stored count against fixed or programmable limits. The two threshold offsets can be loaded over a parallel strobe or shifted in one bit per clock.

There are two resets. The hard reset returns every setting to its default. The soft reset only empties the queue and keeps the offsets and the read mode.

Top module: `dualmode_queue`

## Requirements
- R1: While `hard_rst` is high on a clock edge, the queue is emptied, `rd_data` is set to 0, both offsets are set to 7 and the read mode is taken from `mode_sel` (0 = standard, 1 = fall-through). No other time changes the mode.
- R2: A clock edge with `soft_rst` high empties the queue, clears the presented word and sets `rd_data` to 0. It leaves both offsets and the read mode unchanged.
- R3: In standard mode, each word needs `rd_en` high on one clock edge. That edge puts the oldest word on `rd_data`, in write order. `rd_data` does not change on edges without an accepted read.
- R4: In fall-through mode, a word written into an empty queue on edge k is on `rd_data`, with `stat_rd` = 1, after edge k+1. No read enable is needed for this.
- R5: In fall-through mode, the presented word stays on `rd_data` until an edge with `rd_en` high. That edge consumes it and presents the next stored word, if there is one. If there is none, `stat_rd` drops to 0 and `rd_data` keeps its value.
- R6: In standard mode, `stat_wr` is full and `stat_rd` is empty. In fall-through mode, `stat_wr` is input-ready (the inverse of full) and `stat_rd` is output-ready.
- R7: `half_full` is 1 when the stored count is at least DEPTH/2+1 (513 by default). The count includes the word presented in fall-through mode.
- R8: `almost_empty` is 1 when count ≤ empty offset. `almost_full` is 1 when count ≥ DEPTH − full offset.
- R9: Each edge with `ofs_stb` high writes `ofs_val` into one offset. The empty offset and the full offset take turns, starting with the empty offset after hard reset. A strobe takes priority over the serial load.
- R10: Each edge with `ser_en` high (and no strobe) shifts in one bit from `ser_bit`. Twenty bits make one load: first the empty offset, LSB first, then the full offset, LSB first. The bit position then wraps back to the start.
- R11: A write while the queue holds DEPTH words is dropped, and so is a read while no word is available. Neither changes the stored words, the count or `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| hard_rst | input | 1 | Synchronous reset of queue and all settings |
| soft_rst | input | 1 | Synchronous reset of the queue only |
| mode_sel | input | 1 | Read mode taken during hard reset: 0 standard, 1 fall-through |
| wr_en | input | 1 | Write request |
| wr_data | input | 9 | Word to write |
| rd_en | input | 1 | Read or consume request |
| rd_data | output | 9 | Output word register |
| ofs_stb | input | 1 | Parallel offset load strobe |
| ofs_val | input | 10 | Parallel offset value |
| ser_en | input | 1 | Serial offset shift enable |
| ser_bit | input | 1 | Serial offset data bit |
| stat_wr | output | 1 | Full (standard) or input-ready (fall-through) |
| stat_rd | output | 1 | Empty (standard) or output-ready (fall-through) |
| half_full | output | 1 | Count at least DEPTH/2+1 |
| almost_full | output | 1 | Count at least DEPTH minus full offset |
| almost_empty | output | 1 | Count at most empty offset |

## Verification
The level flags and both status outputs come straight from the count register. They therefore change just after the edge that accepts a write or read, and the bench samples them at the next falling edge. In standard mode a word is due on `rd_data` one edge after its read request. In fall-through mode the first word is due two edges after its write, and each later word one edge after the consume. The bench checks one falling edge after the write and again one edge later, so a one-cycle slip in either direction shows. Offset changes are checked by stepping the count one word below and one word on the new limit.

// File: rtl/dq_pkg.sv
package dq_pkg;

  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FALL = 1'b1
  } rd_mode_e;

  function automatic logic past_half(input int unsigned lvl, input int unsigned depth);
    return lvl >= (depth / 2) + 1;
  endfunction

  function automatic logic near_empty(input int unsigned lvl, input int unsigned ofs);
    return lvl <= ofs;
  endfunction

  function automatic logic near_full(input int unsigned lvl, input int unsigned ofs,
                                     input int unsigned depth);
    return (lvl + ofs) >= depth;
  endfunction

endpackage

// File: rtl/dq_offsets.sv
module dq_offsets #(
  parameter int OW  = 10,
  parameter int DEF = 7
) (
  input  logic          clk,
  input  logic          hard_rst,
  input  logic          ld_stb,
  input  logic [OW-1:0] ld_val,
  input  logic          ser_en,
  input  logic          ser_bit,
  output logic [OW-1:0] ae_ofs,
  output logic [OW-1:0] af_ofs
);
  localparam int IW = $clog2(2 * OW);

  logic [IW-1:0] ser_idx;
  logic          ld_sel;
  logic          ser_lo;
  logic [OW-1:0] ae_mask, af_mask;
  logic [OW-1:0] ae_q, af_q;

  assign ser_lo  = ser_idx < IW'(OW);
  assign ae_mask = ser_lo ? (OW'(1) << ser_idx) : '0;
  assign af_mask = ser_lo ? '0 : (OW'(1) << (ser_idx - IW'(OW)));

  always_ff @(posedge clk) begin
    if (hard_rst) begin
      ae_q    <= OW'(DEF);
      af_q    <= OW'(DEF);
      ld_sel  <= 1'b0;
      ser_idx <= '0;
    end else if (ld_stb) begin
      if (!ld_sel) ae_q <= ld_val;
      else         af_q <= ld_val;
      ld_sel <= ~ld_sel;
    end else if (ser_en) begin
      ae_q    <= (ae_q & ~ae_mask) | (ser_bit ? ae_mask : '0);
      af_q    <= (af_q & ~af_mask) | (ser_bit ? af_mask : '0);
      ser_idx <= (ser_idx == IW'(2 * OW - 1)) ? '0 : ser_idx + 1'b1;
    end
  end

  assign ae_ofs = ae_q;
  assign af_ofs = af_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (hard_rst)
    (!ld_stb && !ser_en) |=> ($stable(ae_ofs) && $stable(af_ofs))); // R10

endmodule

// File: rtl/dq_store.sv
module dq_store #(
  parameter int W     = 9,
  parameter int DEPTH = 1024
) (
  input  logic                     clk,
  input  logic                     clr,
  input  logic                     push,
  input  logic [W-1:0]             din,
  input  logic                     pop,
  output logic [W-1:0]             head,
  output logic [$clog2(DEPTH):0]   cnt
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) mem[wptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
    end
  end

  assign head = mem[rptr[AW-1:0]];
  assign cnt  = wptr - rptr;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (clr)
    pop |-> (cnt != '0)); // R11
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (clr)
    push |-> (cnt < (AW+1)'(DEPTH))); // R11

endmodule

// File: rtl/dualmode_queue.sv
module dualmode_queue
  import dq_pkg::*;
#(
  parameter int W       = 9,
  parameter int DEPTH   = 1024,
  parameter int OW      = $clog2(DEPTH),
  parameter int OFS_DEF = 7
) (
  input  logic          clk,
  input  logic          hard_rst,
  input  logic          soft_rst,
  input  logic          mode_sel,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  input  logic          ofs_stb,
  input  logic [OW-1:0] ofs_val,
  input  logic          ser_en,
  input  logic          ser_bit,
  output logic          stat_wr,
  output logic          stat_rd,
  output logic          half_full,
  output logic          almost_full,
  output logic          almost_empty
);
  localparam int LW = $clog2(DEPTH) + 1;

  rd_mode_e      mode_q;
  logic          clr;
  logic [LW-1:0] lvl, mem_cnt;
  logic          full_w, empty_w, mem_has;
  logic          wr_acc, pop_std, pop_fall, consume, pop, rd_acc;
  logic          ov;
  logic [W-1:0]  head, dout;
  logic [OW-1:0] ae_ofs, af_ofs;

  assign clr = hard_rst | soft_rst;

  dq_offsets #(.OW(OW), .DEF(OFS_DEF)) u_ofs (
    .clk(clk), .hard_rst(hard_rst), .ld_stb(ofs_stb), .ld_val(ofs_val),
    .ser_en(ser_en), .ser_bit(ser_bit), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  dq_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .clr(clr), .push(wr_acc), .din(wr_data),
    .pop(pop), .head(head), .cnt(mem_cnt)
  );

  // acceptance and movement events
  assign full_w   = lvl == LW'(DEPTH);
  assign empty_w  = lvl == '0;
  assign mem_has  = mem_cnt != '0;
  assign wr_acc   = wr_en & ~full_w;
  assign pop_std  = rd_en & mem_has;
  assign pop_fall = mem_has & (~ov | rd_en);
  assign consume  = rd_en & ov;
  assign pop      = (mode_q == RD_FALL) ? pop_fall : pop_std;
  assign rd_acc   = (mode_q == RD_FALL) ? consume : pop_std;

  always_ff @(posedge clk) begin
    if (hard_rst) mode_q <= rd_mode_e'(mode_sel);
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      lvl  <= '0;
      ov   <= 1'b0;
      dout <= '0;
    end else begin
      case ({wr_acc, rd_acc})
        2'b10:   lvl <= lvl + 1'b1;
        2'b01:   lvl <= lvl - 1'b1;
        default: lvl <= lvl;
      endcase
      if (mode_q == RD_FALL) begin
        if (pop)          ov <= 1'b1;
        else if (consume) ov <= 1'b0;
      end
      if (pop) dout <= head;
    end
  end

  assign rd_data      = dout;
  assign stat_wr      = (mode_q == RD_FALL) ? ~full_w : full_w;
  assign stat_rd      = (mode_q == RD_FALL) ? ov : empty_w;
  assign half_full    = past_half(32'(lvl), DEPTH);
  assign almost_empty = near_empty(32'(lvl), 32'(ae_ofs));
  assign almost_full  = near_full(32'(lvl), 32'(af_ofs), DEPTH);

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (hard_rst)
    soft_rst |=> (lvl == '0 && !ov)); // R2
  AST_OFS_KEEP: assert property (@(posedge clk) disable iff (hard_rst)
    (soft_rst && !ofs_stb && !ser_en) |=> ($stable(ae_ofs) && $stable(af_ofs))); // R2
  AST_STD_HOLD: assert property (@(posedge clk) disable iff (clr)
    (mode_q == RD_STD && !rd_en) |=> $stable(rd_data)); // R3
  AST_FALL_SHOW: assert property (@(posedge clk) disable iff (clr)
    (mode_q == RD_FALL && !ov && mem_cnt != '0) |=> ov); // R4
  AST_FALL_HOLD: assert property (@(posedge clk) disable iff (clr)
    (mode_q == RD_FALL && ov && !rd_en) |=> (ov && $stable(rd_data))); // R5
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (clr)
    (full_w && wr_en && !rd_acc) |=> (lvl == $past(lvl))); // R11
  AST_LVL_RANGE: assert property (@(posedge clk) disable iff (clr)
    lvl <= LW'(DEPTH)); // R11

endmodule

// File: tb/dualmode_queue_test.sv
`timescale 1ns/1ps
module dualmode_queue_test;
  localparam int W = 9;
  localparam int DEPTH = 1024;
  localparam int OW = 10;

  logic clk = 1'b0;
  logic hard_rst = 1'b1, soft_rst = 1'b0, mode_sel = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, ofs_stb = 1'b0, ser_en = 1'b0, ser_bit = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [OW-1:0] ofs_val = '0;
  logic [W-1:0] rd_data;
  logic stat_wr, stat_rd, half_full, almost_full, almost_empty;

  int nvec = 0, nbad = 0, mlvl = 0;
  logic [W-1:0] sb[$];
  logic [W-1:0] dseq = 9'h011;
  logic [W-1:0] last = '0;

  always #2.5 clk = ~clk;

  dualmode_queue uut (
    .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .mode_sel(mode_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .ofs_stb(ofs_stb), .ofs_val(ofs_val), .ser_en(ser_en), .ser_bit(ser_bit),
    .stat_wr(stat_wr), .stat_rd(stat_rd), .half_full(half_full),
    .almost_full(almost_full), .almost_empty(almost_empty)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: pushes the expected word into the scoreboard when the model accepts it
  task automatic write_word(input logic [W-1:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0;
    if (mlvl < DEPTH) begin sb.push_back(d); mlvl++; end
  endtask

  task automatic fill_to(input int n);
    while (mlvl < n) begin write_word(dseq); dseq = dseq + 9'd37; end
  endtask

  // standard-mode monitor step: pop scoreboard and compare one edge after request
  task automatic read_std();
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    if (mlvl > 0) begin
      last = sb.pop_front(); mlvl--;
      check("R3 ordered read", 32'(rd_data), 32'(last));
    end else
      check("R11 empty read keeps data", 32'(rd_data), 32'(last));
  endtask

  // fall-through monitor step: presented word must be scoreboard head
  task automatic read_fall();
    check("R5 presented word", 32'(rd_data), 32'(sb[0]));
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    void'(sb.pop_front()); mlvl--;
  endtask

  task automatic do_soft();
    soft_rst = 1'b1; tick(); soft_rst = 1'b0;
    sb.delete(); mlvl = 0; last = '0;
  endtask

  task automatic ser_load(input logic [OW-1:0] ae, input logic [OW-1:0] af);
    for (int i = 0; i < 2 * OW; i++) begin
      ser_en = 1'b1;
      ser_bit = (i < OW) ? ae[i] : af[i - OW];
      tick();
    end
    ser_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    nvec++; nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    @(negedge clk); tick(); tick();
    hard_rst = 1'b0;
    // R1 reset state, standard mode
    check("R1 empty after hard reset", 32'(stat_rd), 1);
    check("R6 std full flag low", 32'(stat_wr), 0);
    check("R1 rd_data cleared", 32'(rd_data), 0);
    check("R7 half low", 32'(half_full), 0);
    check("R8 almost_empty at 0", 32'(almost_empty), 1);
    check("R8 almost_full at 0", 32'(almost_full), 0);

    // R3 basic ordering
    fill_to(5);
    check("R6 std not empty", 32'(stat_rd), 0);
    check("R3 no read no data", 32'(rd_data), 0);
    for (int i = 0; i < 5; i++) read_std();
    check("R6 std empty again", 32'(stat_rd), 1);
    read_std(); // R11

    // R1 default offsets, R7 half, R8 thresholds
    fill_to(7);    check("R1 default empty offset 7", 32'(almost_empty), 1);
    fill_to(8);    check("R8 almost_empty off at 8", 32'(almost_empty), 0);
    fill_to(512);  check("R7 half low at 512", 32'(half_full), 0);
    fill_to(513);  check("R7 half high at 513", 32'(half_full), 1);
    fill_to(1016); check("R8 almost_full low at 1016", 32'(almost_full), 0);
    fill_to(1017); check("R1 default full offset 7", 32'(almost_full), 1);
    fill_to(1024); check("R6 std full", 32'(stat_wr), 1);
    write_word(9'h1AA); // R11 dropped, model does not push
    check("R11 full stays full", 32'(stat_wr), 1);
    while (mlvl > 0) read_std();
    check("R11 drained to empty", 32'(stat_rd), 1);

    // R9 parallel load
    ofs_stb = 1'b1; ofs_val = 10'd3; tick();
    ofs_val = 10'd20; tick();
    ofs_stb = 1'b0;
    fill_to(3);    check("R9 empty offset 3 hit", 32'(almost_empty), 1);
    fill_to(4);    check("R9 empty offset 3 miss", 32'(almost_empty), 0);
    fill_to(1003); check("R9 full offset 20 miss", 32'(almost_full), 0);
    fill_to(1004); check("R9 full offset 20 hit", 32'(almost_full), 1);

    // R2 soft reset keeps offsets
    do_soft();
    check("R2 empty after soft reset", 32'(stat_rd), 1);
    check("R2 rd_data cleared", 32'(rd_data), 0);
    check("R2 half cleared", 32'(half_full), 0);
    fill_to(3);    check("R2 empty offset kept hit", 32'(almost_empty), 1);
    fill_to(4);    check("R2 empty offset kept miss", 32'(almost_empty), 0);
    fill_to(1003); check("R2 full offset kept miss", 32'(almost_full), 0);
    fill_to(1004); check("R2 full offset kept hit", 32'(almost_full), 1);
    do_soft();

    // R10 serial load
    ser_load(10'd5, 10'd100);
    fill_to(5);   check("R10 serial empty offset hit", 32'(almost_empty), 1);
    fill_to(6);   check("R10 serial empty offset miss", 32'(almost_empty), 0);
    fill_to(923); check("R10 serial full offset miss", 32'(almost_full), 0);
    fill_to(924); check("R10 serial full offset hit", 32'(almost_full), 1);
    do_soft();
    // R9 third strobe targets empty offset again
    ofs_stb = 1'b1; ofs_val = 10'd2; tick(); ofs_stb = 1'b0;
    fill_to(2); check("R9 alternation hit", 32'(almost_empty), 1);
    fill_to(3); check("R9 alternation miss", 32'(almost_empty), 0);

    // R1 hard reset into fall-through mode
    mode_sel = 1'b1; hard_rst = 1'b1; tick(); tick(); hard_rst = 1'b0;
    sb.delete(); mlvl = 0;
    check("R6 fall input ready", 32'(stat_wr), 1);
    check("R6 fall output not ready", 32'(stat_rd), 0);

    // R4 first word falls through
    wr_en = 1'b1; wr_data = 9'h055; tick(); wr_en = 1'b0;
    check("R4 not yet presented", 32'(stat_rd), 0);
    tick();
    check("R4 presented flag", 32'(stat_rd), 1);
    check("R4 presented word", 32'(rd_data), 32'h055);
    wr_en = 1'b1; wr_data = 9'h0F0; tick();
    wr_data = 9'h10F; tick(); wr_en = 1'b0;
    tick(); tick();
    check("R5 held without rd_en", 32'(rd_data), 32'h055);
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    check("R5 second word", 32'(rd_data), 32'h0F0);
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    check("R5 third word", 32'(rd_data), 32'h10F);
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    check("R5 output ready drops", 32'(stat_rd), 0);
    check("R5 data kept after last", 32'(rd_data), 32'h10F);
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    check("R11 fall empty read ignored", 32'(stat_rd), 0);
    check("R11 fall empty read data", 32'(rd_data), 32'h10F);

    // R1 offsets restored by hard reset, fall-mode fill and drain
    fill_to(7);    check("R1 offset default restored", 32'(almost_empty), 1);
    fill_to(8);    check("R1 offset default restored miss", 32'(almost_empty), 0);
    fill_to(1024); check("R6 fall input not ready", 32'(stat_wr), 0);
    write_word(9'h0AB); // R11 dropped
    while (mlvl > 0) read_fall();
    check("R5 fall drained", 32'(stat_rd), 0);

    // R2 soft reset keeps fall mode
    fill_to(2);
    do_soft();
    check("R2 mode kept input ready", 32'(stat_wr), 1);
    check("R2 fall output cleared", 32'(stat_rd), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule